// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sits beside a processor core and decides when the subsystem leaves normal run for a low-power state, and when it comes back. The core reports three single-cycle strobes: wait-for-interrupt, wait-for-event and return-from-handler. Software sets a deep-sleep bit, a sleep-on-exit bit, a 3-bit depth field and a send-event-on-pending bit. Per-line wakeup pending flags arrive with interrupt-mode and event-mode masks, together with the interrupt-controller enables for the same lines. Per-peripheral wakeup flags, oscillator requests and frame-reject signals come from the wakeup-capable peripherals.

A qualified request enters one of three states: a light sleep, in which only the core clock stops, or one of two stop depths, in which every oscillator and the PLL are switched off. The block drops the request if any wakeup source is already pending. The block records how it was entered, and that record decides which lines may wake it. Leaving a stop state passes through a recovery state, timed by down-counters for oscillator start, regulator recovery and flash recovery. The core clock comes back, and a one-cycle done pulse is issued, only after the combined delay. In the deeper stop variant a wakeup-capable peripheral may borrow the fast internal RC oscillator while the rest of the subsystem stays stopped.

Top module: `lp_stop_ctrl`

## Requirements
- R1: After reset the state output is 2'b00 (run). The core clock enable and all four oscillator/PLL enables are 1. Every oscillator grant bit is 0 and the done output is 0.
- R2: A wait-for-interrupt or wait-for-event strobe in run, with deep_en=1 and depth field 3'b001, moves the state to 2'b10 (stop) on that clock edge. Depth 3'b010 does the same but selects the deeper variant. With deep_en=0 the strobe is ignored.
- R3: A return-from-handler strobe requests entry exactly like wait-for-interrupt, but only when exit_sleep_en=1. Otherwise the strobe is ignored.
- R4: If any line_pend bit or any per_wake_flag bit is 1 at the edge that samples an entry strobe, the block stays in run with the core clock enabled.
- R5: A qualified strobe with any depth value other than 3'b001 or 3'b010 enters sleep (state 2'b01). Sleep stops the core clock and leaves every oscillator and the PLL enabled.
- R6: In stop, core_clk_en, pll_en, ms_rc_en and xtal_en are 0. fast_rc_en is 0 unless some oscillator grant bit is 1.
- R7: After entry by wait-for-interrupt or return-from-handler, only a line with line_pend, line_irq_mask and irq_enable all set wakes the block.
- R8: After entry by wait-for-event with sev_pend_en=0, only a line with line_pend and line_evt_mask both set wakes the block.
- R9: After entry by wait-for-event with sev_pend_en=1, a line with line_pend and line_irq_mask set wakes the block, whatever its irq_enable bit.
- R10: In the deeper stop variant, an asserted per_osc_req bit sets that peripheral's grant bit on the next edge and raises fast_rc_en. An asserted per_frame_reject bit clears that grant bit, and wins if it arrives together with the request. In the shallower stop variant and outside stop, every grant bit stays 0.
- R11: A wake from stop moves the state to 2'b11 (recovery), with the oscillators on and the core clock off. The state returns to run, with core_clk_en=1 and wake_done=1, on the (max(T_OSC,T_REG)+T_FLASH+3)th rising edge, counting the edge that first samples the qualifying line as the first.
- R12: The entry kind is captured at entry. Changing sev_pend_en while stopped does not change which lines wake the block.
- R13: A wake from sleep returns to run with wake_done=1 on the edge that samples the qualifying line. wake_done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_stb | input | 1 | Wait-for-interrupt strobe |
| wfe_stb | input | 1 | Wait-for-event strobe |
| ret_stb | input | 1 | Return-from-handler strobe |
| deep_en | input | 1 | Deep-sleep control bit |
| exit_sleep_en | input | 1 | Sleep-on-exit control bit |
| depth_sel | input | 3 | Low-power depth field |
| sev_pend_en | input | 1 | Send-event-on-pending bit |
| line_pend | input | N_LINE | Wakeup line pending flags |
| line_irq_mask | input | N_LINE | Line configured in interrupt mode |
| line_evt_mask | input | N_LINE | Line configured in event mode |
| irq_enable | input | N_LINE | Interrupt-controller enable per line |
| per_wake_flag | input | N_PER | Peripheral wakeup flags |
| per_osc_req | input | N_PER | Peripheral request for fast RC oscillator |
| per_frame_reject | input | N_PER | Peripheral: received frame was not a wakeup |
| state_o | output | 2 | 00 run, 01 sleep, 10 stop, 11 recovery |
| core_clk_en | output | 1 | Core-domain clock enable |
| pll_en | output | 1 | PLL enable |
| ms_rc_en | output | 1 | Multi-speed RC oscillator enable |
| fast_rc_en | output | 1 | Fast internal RC oscillator enable |
| xtal_en | output | 1 | External crystal oscillator enable |
| osc_grant | output | N_PER | Per-peripheral fast RC clock grant |
| wake_done | output | 1 | One-cycle pulse on return to run |

## Verification
Two collisions matter most. The first is a wakeup line that becomes pending in the same cycle as the entry strobe. The bench drives both on one falling edge and expects the block to stay in run with the core clock on. The second is a peripheral that raises its oscillator request and its frame-reject in the same cycle while in deep stop. The bench expects the grant bit and fast_rc_en to stay low on the following edge.

// File: rtl/dstop_pkg.sv
package dstop_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'b00,
      ST_SLEEP = 2'b01,
      ST_STOP  = 2'b10,
      ST_WAKE  = 2'b11
   } pstate_e;

   typedef enum logic [1:0] {
      ENT_IRQ     = 2'b00,
      ENT_EVT     = 2'b01,
      ENT_EVT_SEV = 2'b10
   } entry_e;

   typedef enum logic [1:0] {
      DEPTH_SLEEP = 2'b00,
      DEPTH_STOP1 = 2'b01,
      DEPTH_STOP2 = 2'b10
   } depth_e;

   localparam logic [2:0] MODE_STOP1 = 3'b001;
   localparam logic [2:0] MODE_STOP2 = 3'b010;
endpackage

// File: rtl/lpsc_entry_qual.sv
module lpsc_entry_qual
   import dstop_pkg::*;
#(
   parameter int N_LINE = 4,
   parameter int N_PER  = 2
) (
   input  logic              wfi_stb,
   input  logic              wfe_stb,
   input  logic              ret_stb,
   input  logic              deep_en,
   input  logic              exit_sleep_en,
   input  logic [2:0]        depth_sel,
   input  logic              sev_pend_en,
   input  logic [N_LINE-1:0] line_pend,
   input  logic [N_PER-1:0]  per_wake_flag,
   output logic              go_o,
   output entry_e            kind_o,
   output depth_e            depth_o
);
   logic trig_irq, trig_evt, busy_src;

   always_comb begin
      trig_irq = wfi_stb | (ret_stb & exit_sleep_en);
      trig_evt = wfe_stb;
      busy_src = (|line_pend) | (|per_wake_flag);
      go_o     = deep_en & (trig_irq | trig_evt) & ~busy_src;
      if (trig_irq)         kind_o = ENT_IRQ;
      else if (sev_pend_en) kind_o = ENT_EVT_SEV;
      else                  kind_o = ENT_EVT;
      case (depth_sel)
         MODE_STOP1: depth_o = DEPTH_STOP1;
         MODE_STOP2: depth_o = DEPTH_STOP2;
         default:    depth_o = DEPTH_SLEEP;
      endcase
   end
endmodule

// File: rtl/lpsc_wake_sel.sv
module lpsc_wake_sel
   import dstop_pkg::*;
#(
   parameter int N_LINE = 4
) (
   input  entry_e            kind_i,
   input  logic [N_LINE-1:0] line_pend,
   input  logic [N_LINE-1:0] line_irq_mask,
   input  logic [N_LINE-1:0] line_evt_mask,
   input  logic [N_LINE-1:0] irq_enable,
   output logic              hit_o
);
   logic [N_LINE-1:0] hit_vec;

   generate
      for (genvar li = 0; li < N_LINE; li++) begin : g_line
         always_comb begin
            case (kind_i)
               ENT_IRQ:     hit_vec[li] = line_pend[li] & line_irq_mask[li] & irq_enable[li];
               ENT_EVT:     hit_vec[li] = line_pend[li] & line_evt_mask[li];
               ENT_EVT_SEV: hit_vec[li] = line_pend[li] & line_irq_mask[li];
               default:     hit_vec[li] = 1'b0;
            endcase
         end
      end
   endgenerate

   assign hit_o = |hit_vec;
endmodule

// File: rtl/lpsc_wake_timer.sv
module lpsc_wake_timer #(
   parameter int T_OSC   = 8,
   parameter int T_REG   = 12,
   parameter int T_FLASH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int MAXT  = (T_OSC > T_REG) ? ((T_OSC > T_FLASH) ? T_OSC : T_FLASH)
                                          : ((T_REG > T_FLASH) ? T_REG : T_FLASH);
   localparam int CNT_W = $clog2(MAXT + 1);

   logic [CNT_W-1:0] osc_q, reg_q, fl_q;
   logic             busy_q, ph_b_q;

   assign done = busy_q & ph_b_q & (fl_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_q  <= '0;
         reg_q  <= '0;
         fl_q   <= '0;
         busy_q <= 1'b0;
         ph_b_q <= 1'b0;
      end else if (start) begin
         osc_q  <= CNT_W'(T_OSC);
         reg_q  <= CNT_W'(T_REG);
         fl_q   <= '0;
         busy_q <= 1'b1;
         ph_b_q <= 1'b0;
      end else if (busy_q) begin
         if (!ph_b_q) begin
            if (osc_q != '0) osc_q <= osc_q - 1'b1;
            if (reg_q != '0) reg_q <= reg_q - 1'b1;
            if (osc_q == '0 && reg_q == '0) begin
               ph_b_q <= 1'b1;
               fl_q   <= CNT_W'(T_FLASH);
            end
         end else if (fl_q != '0) begin
            fl_q <= fl_q - 1'b1;
         end else begin
            busy_q <= 1'b0;
            ph_b_q <= 1'b0;
         end
      end
   end

   assert_no_early_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !done);
   assert_done_after_osc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (osc_q == '0 && reg_q == '0));
endmodule

// File: rtl/lpsc_osc_grant.sv
module lpsc_osc_grant #(
   parameter int N_PER = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [N_PER-1:0] req,
   input  logic [N_PER-1:0] reject,
   output logic [N_PER-1:0] grant
);
   generate
      for (genvar pi = 0; pi < N_PER; pi++) begin : g_per
         logic g_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     g_q <= 1'b0;
            else if (!active || reject[pi]) g_q <= 1'b0;
            else if (req[pi])               g_q <= 1'b1;
         end
         assign grant[pi] = g_q;
      end
   endgenerate

   assert_grant_only_deep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (grant == '0));
   assert_reject_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reject != '0) |=> ((grant & $past(reject)) == '0));
endmodule

// File: rtl/lp_stop_ctrl.sv
module lp_stop_ctrl
   import dstop_pkg::*;
#(
   parameter int N_LINE  = 4,
   parameter int N_PER   = 2,
   parameter int T_OSC   = 8,
   parameter int T_REG   = 12,
   parameter int T_FLASH = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wfi_stb,
   input  logic              wfe_stb,
   input  logic              ret_stb,
   input  logic              deep_en,
   input  logic              exit_sleep_en,
   input  logic [2:0]        depth_sel,
   input  logic              sev_pend_en,
   input  logic [N_LINE-1:0] line_pend,
   input  logic [N_LINE-1:0] line_irq_mask,
   input  logic [N_LINE-1:0] line_evt_mask,
   input  logic [N_LINE-1:0] irq_enable,
   input  logic [N_PER-1:0]  per_wake_flag,
   input  logic [N_PER-1:0]  per_osc_req,
   input  logic [N_PER-1:0]  per_frame_reject,
   output logic [1:0]        state_o,
   output logic              core_clk_en,
   output logic              pll_en,
   output logic              ms_rc_en,
   output logic              fast_rc_en,
   output logic              xtal_en,
   output logic [N_PER-1:0]  osc_grant,
   output logic              wake_done
);
   generate
      if (N_LINE < 1) begin : g_bad_lines
         $error("N_LINE must be at least 1");
      end
      if (N_PER < 1) begin : g_bad_per
         $error("N_PER must be at least 1");
      end
      if (T_OSC < 1 || T_REG < 1 || T_FLASH < 1) begin : g_bad_times
         $error("recovery times must be at least 1 cycle");
      end
   endgenerate

   pstate_e state_q;
   entry_e  ent_q;
   logic    deep2_q;
   logic    done_q;

   logic    go;
   entry_e  req_kind;
   depth_e  req_depth;
   logic    wake_hit;
   logic    tmr_start, tmr_done;
   logic    osc_on, grant_active;

   lpsc_entry_qual #(.N_LINE(N_LINE), .N_PER(N_PER)) u_qual (
      .wfi_stb       (wfi_stb),
      .wfe_stb       (wfe_stb),
      .ret_stb       (ret_stb),
      .deep_en       (deep_en),
      .exit_sleep_en (exit_sleep_en),
      .depth_sel     (depth_sel),
      .sev_pend_en   (sev_pend_en),
      .line_pend     (line_pend),
      .per_wake_flag (per_wake_flag),
      .go_o          (go),
      .kind_o        (req_kind),
      .depth_o       (req_depth)
   );

   lpsc_wake_sel #(.N_LINE(N_LINE)) u_wsel (
      .kind_i        (ent_q),
      .line_pend     (line_pend),
      .line_irq_mask (line_irq_mask),
      .line_evt_mask (line_evt_mask),
      .irq_enable    (irq_enable),
      .hit_o         (wake_hit)
   );

   assign tmr_start = (state_q == ST_STOP) & wake_hit;

   lpsc_wake_timer #(.T_OSC(T_OSC), .T_REG(T_REG), .T_FLASH(T_FLASH)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .done  (tmr_done)
   );

   assign grant_active = (state_q == ST_STOP) & deep2_q;

   lpsc_osc_grant #(.N_PER(N_PER)) u_grant (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (grant_active),
      .req    (per_osc_req),
      .reject (per_frame_reject),
      .grant  (osc_grant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         ent_q   <= ENT_IRQ;
         deep2_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_RUN: begin
               if (go) begin
                  ent_q   <= req_kind;
                  deep2_q <= (req_depth == DEPTH_STOP2);
                  state_q <= (req_depth == DEPTH_SLEEP) ? ST_SLEEP : ST_STOP;
               end
            end
            ST_SLEEP: begin
               if (wake_hit) begin
                  state_q <= ST_RUN;
                  done_q  <= 1'b1;
               end
            end
            ST_STOP: begin
               if (wake_hit) state_q <= ST_WAKE;
            end
            ST_WAKE: begin
               if (tmr_done) begin
                  state_q <= ST_RUN;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign osc_on      = (state_q != ST_STOP);
   assign state_o     = state_q;
   assign core_clk_en = (state_q == ST_RUN);
   assign pll_en      = osc_on;
   assign ms_rc_en    = osc_on;
   assign xtal_en     = osc_on;
   assign fast_rc_en  = osc_on | (|osc_grant);
   assign wake_done   = done_q;

   assert_pend_blocks_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && ((|line_pend) || (|per_wake_flag))) |=> (state_q == ST_RUN));
   assert_stop_gates_clocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOP) |-> (!core_clk_en && !pll_en && !ms_rc_en && !xtal_en));
   assert_stop_needs_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STOP && line_pend == '0) |=> (state_q == ST_STOP));
   assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |=> !wake_done);
   assert_done_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_done |-> (core_clk_en && state_q == ST_RUN));
endmodule

// File: tb/tb_lp_stop_ctrl.sv
`timescale 1ns/1ps
module tb_lp_stop_ctrl;
   localparam int NL = 4, NP = 2, TO = 8, TR = 12, TF = 5;
   localparam int LAT = ((TO > TR) ? TO : TR) + TF + 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wfi_stb = 0, wfe_stb = 0, ret_stb = 0;
   logic deep_en = 1, exit_sleep_en = 0, sev_pend_en = 0;
   logic [2:0] depth_sel = 3'b001;
   logic [NL-1:0] line_pend = 0, line_irq_mask = 0, line_evt_mask = 0, irq_enable = 0;
   logic [NP-1:0] per_wake_flag = 0, per_osc_req = 0, per_frame_reject = 0;
   logic [1:0] state_o;
   logic core_clk_en, pll_en, ms_rc_en, fast_rc_en, xtal_en, wake_done;
   logic [NP-1:0] osc_grant;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   lp_stop_ctrl #(.N_LINE(NL), .N_PER(NP), .T_OSC(TO), .T_REG(TR), .T_FLASH(TF)) dut (
      .clk(clk), .rst_n(rst_n), .wfi_stb(wfi_stb), .wfe_stb(wfe_stb), .ret_stb(ret_stb),
      .deep_en(deep_en), .exit_sleep_en(exit_sleep_en), .depth_sel(depth_sel),
      .sev_pend_en(sev_pend_en), .line_pend(line_pend), .line_irq_mask(line_irq_mask),
      .line_evt_mask(line_evt_mask), .irq_enable(irq_enable), .per_wake_flag(per_wake_flag),
      .per_osc_req(per_osc_req), .per_frame_reject(per_frame_reject), .state_o(state_o),
      .core_clk_en(core_clk_en), .pll_en(pll_en), .ms_rc_en(ms_rc_en),
      .fast_rc_en(fast_rc_en), .xtal_en(xtal_en), .osc_grant(osc_grant),
      .wake_done(wake_done));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_lines();
      line_pend = 0; line_irq_mask = 0; line_evt_mask = 0; irq_enable = 0;
      per_wake_flag = 0; per_osc_req = 0; per_frame_reject = 0;
   endtask

   task automatic pulse(input int which);
      if (which == 0) wfi_stb = 1'b1;
      else if (which == 1) wfe_stb = 1'b1;
      else ret_stb = 1'b1;
      @(negedge clk);
      wfi_stb = 0; wfe_stb = 0; ret_stb = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // qualifying line already driven; counts edges until wake_done
   task automatic time_wake(input string req);
      int n = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            check({req, " recovery state"}, state_o, 2'b11);
            check({req, " recovery core off"}, core_clk_en, 1'b0);
            check({req, " recovery osc on"}, {pll_en, ms_rc_en, fast_rc_en, xtal_en}, 4'hf);
         end
         if (wake_done === 1'b1) break;
      end
      check({req, " R11 latency"}, n, LAT);
      check({req, " R11 run after wake"}, {state_o, core_clk_en}, 3'b001);
      clear_lines();
      @(negedge clk);
      check({req, " R13 done one cycle"}, wake_done, 1'b0);
   endtask

   task automatic t_reset();
      check("R1 state", state_o, 2'b00);
      check("R1 enables", {core_clk_en, pll_en, ms_rc_en, fast_rc_en, xtal_en}, 5'h1f);
      check("R1 grant", osc_grant, 0);
      check("R1 done", wake_done, 0);
   endtask

   task automatic t_wfi_stop1();
      depth_sel = 3'b001;
      pulse(0);
      check("R2 wfi enters stop", state_o, 2'b10);
      check("R6 all gated", {core_clk_en, pll_en, ms_rc_en, fast_rc_en, xtal_en}, 5'h00);
      line_pend = 4'b0001; line_evt_mask = 4'b0001;
      idle(3);
      check("R7 event-only line ignored", state_o, 2'b10);
      line_pend = 4'b0011; line_irq_mask = 4'b0010;
      idle(3);
      check("R7 disabled irq line ignored", state_o, 2'b10);
      irq_enable = 4'b0010;
      time_wake("R7 enabled irq line wakes");
   endtask

   task automatic t_pend_drop();
      line_pend = 4'b0100;
      pulse(0);
      check("R4 pending line drops entry", {state_o, core_clk_en}, 3'b001);
      line_pend = 0; per_wake_flag = 2'b01;
      pulse(1);
      check("R4 peripheral flag drops entry", {state_o, core_clk_en}, 3'b001);
      per_wake_flag = 0;
      // collision: line raised in the same cycle as the strobe
      wfi_stb = 1; line_pend = 4'b1000;
      @(negedge clk);
      wfi_stb = 0;
      check("R4 same-cycle line drops entry", {state_o, core_clk_en}, 3'b001);
      clear_lines();
      idle(1);
   endtask

   task automatic t_deep_off();
      deep_en = 0;
      pulse(0);
      check("R2 deep_en clear ignored", state_o, 2'b00);
      deep_en = 1;
   endtask

   task automatic t_ret();
      exit_sleep_en = 0;
      pulse(2);
      check("R3 return without exit bit ignored", state_o, 2'b00);
      exit_sleep_en = 1;
      pulse(2);
      check("R3 return enters stop", state_o, 2'b10);
      exit_sleep_en = 0;
      line_pend = 4'b0001; line_irq_mask = 4'b0001; irq_enable = 4'b0001;
      time_wake("R3 return wake");
   endtask

   task automatic t_wfe_nosev();
      sev_pend_en = 0;
      pulse(1);
      check("R8 wfe enters stop", state_o, 2'b10);
      sev_pend_en = 1;
      line_pend = 4'b0100; line_irq_mask = 4'b0100; irq_enable = 4'b0100;
      idle(3);
      check("R8 R12 irq line ignored after event entry", state_o, 2'b10);
      sev_pend_en = 0;
      line_evt_mask = 4'b0100;
      time_wake("R8 event line wakes");
   endtask

   task automatic t_wfe_sev();
      sev_pend_en = 1;
      pulse(1);
      check("R9 wfe sev enters stop", state_o, 2'b10);
      sev_pend_en = 0;
      line_pend = 4'b0001; line_evt_mask = 4'b0001;
      idle(3);
      check("R9 event-only line ignored", state_o, 2'b10);
      line_pend = 4'b0011; line_irq_mask = 4'b0010; irq_enable = 0;
      time_wake("R9 R12 irq-mode line wakes without enable");
   endtask

   task automatic t_sleep();
      depth_sel = 3'b000;
      pulse(0);
      check("R5 sleep state", state_o, 2'b01);
      check("R5 sleep enables", {core_clk_en, pll_en, ms_rc_en, fast_rc_en, xtal_en}, 5'h0f);
      depth_sel = 3'b111;
      line_pend = 4'b0001; line_irq_mask = 4'b0001; irq_enable = 4'b0001;
      @(negedge clk);
      check("R13 sleep wake one edge", {state_o, wake_done}, 3'b001);
      clear_lines();
      @(negedge clk);
      check("R13 sleep done one cycle", wake_done, 1'b0);
      pulse(0);
      check("R5 depth 111 sleeps", state_o, 2'b01);
      line_pend = 4'b0010; line_irq_mask = 4'b0010; irq_enable = 4'b0010;
      @(negedge clk);
      check("R13 second sleep wake", {state_o, wake_done}, 3'b001);
      clear_lines();
      idle(1);
   endtask

   task automatic t_stop2_grant();
      depth_sel = 3'b010;
      pulse(0);
      check("R2 depth 010 enters stop", state_o, 2'b10);
      per_osc_req = 2'b10;
      @(negedge clk);
      check("R10 grant to requester only", osc_grant, 2'b10);
      check("R10 fast rc on", {fast_rc_en, pll_en, ms_rc_en, xtal_en, core_clk_en}, 5'h10);
      per_osc_req = 0; per_frame_reject = 2'b10;
      @(negedge clk);
      per_frame_reject = 0;
      check("R10 reject clears grant", {osc_grant, fast_rc_en}, 3'b000);
      per_osc_req = 2'b01; per_frame_reject = 2'b01;
      @(negedge clk);
      check("R10 reject wins same cycle", {osc_grant, fast_rc_en}, 3'b000);
      per_frame_reject = 0;
      @(negedge clk);
      check("R10 second requester", osc_grant, 2'b01);
      line_pend = 4'b0001; line_irq_mask = 4'b0001; irq_enable = 4'b0001;
      time_wake("R10 deep stop wake");
      check("R10 grant cleared outside stop", osc_grant, 0);
   endtask

   task automatic t_stop1_nogrant();
      depth_sel = 3'b001;
      pulse(0);
      per_osc_req = 2'b11;
      idle(2);
      check("R10 no grant in shallow stop", {osc_grant, fast_rc_en}, 3'b000);
      line_pend = 4'b0001; line_irq_mask = 4'b0001; irq_enable = 4'b0001;
      time_wake("R11 shallow stop wake");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_wfi_stop1();
      t_pend_drop();
      t_deep_off();
      t_ret();
      t_wfe_nosev();
      t_wfe_sev();
      t_sleep();
      t_stop2_grant();
      t_stop1_nogrant();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule